// File: doc/BRIEF.md
# Programmable Interval Tick Timer

This block raises a periodic level interrupt whose rate is set by software through a 9-bit reload value. It runs on the system clock and counts pulses of a free-running 1 kHz reference strobe that arrives as a one-cycle enable. The tick rate is the base rate divided by one more than the reload value using integer division. The period is the whole number of strobes that corresponds to that truncated rate, so a reload of 41 gives a period of 43 strobes and not 42.

Software sees two 32-bit word registers. One sets the reload value and restarts the timer. The other is a count register that always reads zero, and reading it acknowledges the interrupt. The interrupt output is a level. It rises when a period expires and stays high until it is acknowledged or the reload register is written. Each expiry starts the next period at once.

The core is a two-state machine. ST_ARMED means no interrupt is pending. ST_PENDING means the interrupt is asserted. Transition T_EXPIRE (ST_ARMED to ST_PENDING) fires on the strobe that completes the period. T_RETRIGGER (ST_PENDING to ST_PENDING) is a further expiry while the interrupt is still pending. T_ACK (ST_PENDING to ST_ARMED) is a count read with no expiry in the same cycle. T_RELOAD (either state to ST_ARMED) is a write to the reload register. T_RELOAD overrides every other transition.

Top module: `itt_tick_timer`

## Requirements
- R1: A write to byte offset 0x228 takes wdata[8:0] as the new reload value and drops bits 31:9. Address bits 1:0 are ignored. Writing 0xABCDFE00 therefore loads reload 0.
- R2: The period in strobes is 1000 / (1000 / (reload+1)) with integer division. Examples: reload 0 gives 1, 2 gives 3, 41 gives 43, 499 gives 500, 511 gives 1000. The strobe sampled at a clock edge that completes the period makes irq high after that same edge, and the next period starts counting from the following strobe.
- R3: A reload write clears the strobe count and makes irq low after the write's clock edge. A strobe sampled at the same edge as the write is not counted.
- R4: Once high, irq stays high until an acknowledge or a reload write. Further expiries while it is high keep it high and restart the period.
- R5: A read at byte offset 0x230 returns 0 on reg_rdata in the same cycle and makes irq low after that clock edge.
- R6: While reset is asserted and after it is released, irq is low, the reload value is 0 (period 1 strobe) and the strobe count is 0.
- R7: Writes to any other offset change neither the period nor irq. Reads at any other offset do not lower irq. Every read returns 0.
- R8: If a period expires at the same clock edge as a read at 0x230, irq is high after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse of the 1 kHz reference |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so it is checked in the same cycle as reg_rd. Every irq effect appears after the one clock edge that samples the cause: an expiring strobe, an acknowledge or a reload write. The bench records the inputs each edge sampled and compares irq at the following falling edge, one cycle after the cause. Expected periods are pushed into a queue by the write driver. The monitor pops a period only when it sees a sampled reload write and counts sampled strobes against it, so irq is compared every cycle against the event due at that edge.

// File: rtl/itt_pkg.sv
package itt_pkg;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_PENDING = 1'b1
    } itt_state_e;

    // Restoring unsigned divider, unrolled over 16 quotient bits.
    function automatic logic [15:0] udiv16(input logic [15:0] num,
                                           input logic [15:0] den);
        logic [16:0] rem;
        logic [15:0] quo;
        rem = '0;
        quo = '0;
        for (int i = 15; i >= 0; i--) begin
            rem = {rem[15:0], num[i]};
            if (rem >= {1'b0, den}) begin
                rem    = rem - {1'b0, den};
                quo[i] = 1'b1;
            end
        end
        return quo;
    endfunction

    // Strobes per period: base / truncated(base / (reload + 1)).
    function automatic logic [15:0] period_of(input logic [15:0] base,
                                              input logic [15:0] reload);
        logic [15:0] rate;
        rate = udiv16(base, reload + 16'd1);
        if (rate == 16'd0) begin
            rate = 16'd1;
        end
        return udiv16(base, rate);
    endfunction

endpackage

// File: rtl/itt_regif.sv
module itt_regif #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int RELOAD_W   = 9,
    parameter int RELOAD_OFS = 'h228,
    parameter int COUNT_OFS  = 'h230
) (
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic                load_en,
    output logic [RELOAD_W-1:0] load_val,
    output logic                ack_en,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam logic [ADDR_W-1:0] RELOAD_A = ADDR_W'(RELOAD_OFS);
    localparam logic [ADDR_W-1:0] COUNT_A  = ADDR_W'(COUNT_OFS);

    logic hit_reload;
    logic hit_count;
    logic unused_bits;

    // Word decode: byte-lane bits do not take part.
    assign hit_reload = reg_addr[ADDR_W-1:2] == RELOAD_A[ADDR_W-1:2];
    assign hit_count  = reg_addr[ADDR_W-1:2] == COUNT_A[ADDR_W-1:2];

    assign load_en  = reg_wr && hit_reload;
    assign load_val = reg_wdata[RELOAD_W-1:0];
    assign ack_en   = reg_rd && hit_count;

    // The count register and every other location read as zero.
    assign reg_rdata = '0;

    assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:RELOAD_W]};

endmodule

// File: rtl/itt_period.sv
module itt_period
    import itt_pkg::*;
#(
    parameter int BASE_HZ  = 1000,
    parameter int RELOAD_W = 9,
    parameter int CNT_W    = 10
) (
    input  logic [RELOAD_W-1:0] reload,
    output logic [CNT_W-1:0]    period
);
    logic [15:0] full;

    always_comb begin
        full   = period_of(16'(BASE_HZ), 16'(reload));
        period = CNT_W'(full);
    end

    // R2: a period is never empty and never longer than the base rate
    always_comb begin
        a_r2_period_range: assert (full >= 16'd1 && full <= 16'(BASE_HZ))
            else $error("period out of range");
    end

endmodule

// File: rtl/itt_fsm.sv
module itt_fsm
    import itt_pkg::*;
#(
    parameter int BASE_HZ  = 1000,
    parameter int RELOAD_W = 9,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             restart,
    input  logic             ack,
    input  logic [CNT_W-1:0] new_period,
    output logic             irq
);
    localparam logic [CNT_W-1:0] RESET_PERIOD =
        CNT_W'(period_of(16'(BASE_HZ), 16'd0));

    itt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic             expire;

    assign expire = strobe && !restart && ((cnt_q + 1'b1) == period_q);

    // Period and strobe counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= RESET_PERIOD;
        end else if (restart) begin
            cnt_q    <= '0;
            period_q <= new_period;
        end else if (strobe) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (restart)     state_d = ST_ARMED;    // T_RELOAD
                else if (expire) state_d = ST_PENDING;  // T_EXPIRE
            end
            ST_PENDING: begin
                if (restart)     state_d = ST_ARMED;    // T_RELOAD
                else if (expire) state_d = ST_PENDING;  // T_RETRIGGER
                else if (ack)    state_d = ST_ARMED;    // T_ACK
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        irq = (state_q == ST_PENDING);
    end

    a_r3_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!irq && cnt_q == '0));

    a_r2_expire_raises: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !restart && !ack) |=> irq);

    a_r5_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !restart) |=> !irq);

    a_r8_expire_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && expire) |=> irq);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < period_q);

endmodule

// File: rtl/itt_tick_timer.sv
module itt_tick_timer #(
    parameter int BASE_HZ    = 1000,
    parameter int RELOAD_W   = 9,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int RELOAD_OFS = 'h228,
    parameter int COUNT_OFS  = 'h230
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(BASE_HZ + 1);

    logic                load_en;
    logic [RELOAD_W-1:0] load_val;
    logic                ack_en;
    logic [CNT_W-1:0]    new_period;

    itt_regif #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RELOAD_W  (RELOAD_W),
        .RELOAD_OFS(RELOAD_OFS),
        .COUNT_OFS (COUNT_OFS)
    ) regif_i (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .load_en  (load_en),
        .load_val (load_val),
        .ack_en   (ack_en),
        .reg_rdata(reg_rdata)
    );

    itt_period #(
        .BASE_HZ (BASE_HZ),
        .RELOAD_W(RELOAD_W),
        .CNT_W   (CNT_W)
    ) period_i (
        .reload(load_val),
        .period(new_period)
    );

    itt_fsm #(
        .BASE_HZ (BASE_HZ),
        .RELOAD_W(RELOAD_W),
        .CNT_W   (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (ref_tick),
        .restart   (load_en),
        .ack       (ack_en),
        .new_period(new_period),
        .irq       (irq)
    );

    // R5 R7: every read returns zero
    a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (reg_rdata == '0));

endmodule

// File: tb/itt_tick_timer_tb_top.sv
module itt_tick_timer_tb_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #10 clk = ~clk;

    int unsigned tb_cyc = 0;
    always @(posedge clk) tb_cyc <= tb_cyc + 1;
    assign ref_tick = (tb_cyc % DIV) == 0;

    itt_tick_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_period(input int r);
        int f;
        f = 1000 / (r + 1);
        return 1000 / f;
    endfunction

    // Inputs as sampled at each rising edge.
    logic s_rst = 1'b1, s_wr = 1'b0, s_rd = 1'b0, s_strobe = 1'b0;
    always @(posedge clk) begin
        s_rst    <= !rst_n;
        s_wr     <= reg_wr && (reg_addr[11:2] == 10'h08A);
        s_rd     <= reg_rd && (reg_addr[11:2] == 10'h08C);
        s_strobe <= ref_tick;
    end

    // Monitor: scoreboard of expected periods and irq level.
    int    cur_p = 1;
    int    cnt = 0;
    bit    exp_irq = 1'b0;
    string tag;
    always @(negedge clk) begin
        if (s_rst) begin
            cur_p   = 1;
            cnt     = 0;
            exp_irq = 1'b0;
            tag     = "R6";
        end else if (s_wr) begin
            if (exp_q.size() > 0) cur_p = exp_q.pop_front();
            cnt     = 0;
            exp_irq = 1'b0;
            tag     = "R3";
        end else begin
            bit hit;
            hit = 1'b0;
            if (s_strobe) begin
                cnt++;
                if (cnt >= cur_p) begin
                    hit = 1'b1;
                    cnt = 0;
                end
            end
            if (hit) begin
                exp_irq = 1'b1;
                tag     = s_rd ? "R8" : "R2";
            end else if (s_rd) begin
                exp_irq = 1'b0;
                tag     = "R5";
            end else begin
                tag = "R4";
            end
        end
        if (!done) chk(irq == exp_irq, tag, int'(irq), int'(exp_irq));
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit push);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        if (push) exp_q.push_back(exp_period(int'(d & 32'h1FF)));
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string t);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = a;
        #1;
        chk(reg_rdata == 32'd0, t, int'(reg_rdata), 0);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (irq !== 1'b1) @(negedge clk);
    endtask

    task automatic run_periods(input int n);
        for (int i = 0; i < n; i++) begin
            wait_irq();
            rd(12'h230, "R5");
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(irq == 1'b0, "R6", int'(irq), 0);
        rst_n = 1'b1;
        // R6: reload 0 after reset means one-strobe periods
        run_periods(2);
        // R2: period table
        wr(12'h228, 32'd2, 1'b1);
        run_periods(3);
        wr(12'h228, 32'd41, 1'b1);
        run_periods(2);
        wr(12'h228, 32'd499, 1'b1);
        run_periods(1);
        // R1: upper bits dropped, 0x3FF loads 511 -> 1000 strobes
        wr(12'h228, 32'h0000_03FF, 1'b1);
        run_periods(1);
        // R1: 0xABCDFE00 loads 0; byte lane bits ignored (0x22B)
        wr(12'h22B, 32'hABCD_FE00, 1'b1);
        run_periods(2);
        // R3: restart in mid-period
        wr(12'h228, 32'd41, 1'b1);
        repeat (20 * DIV) @(negedge clk);
        wr(12'h228, 32'd41, 1'b1);
        run_periods(1);
        // R3: write coinciding with a strobe
        wr(12'h228, 32'd2, 1'b1);
        @(negedge clk);
        while ((tb_cyc % DIV) != 0) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h228; reg_wdata = 32'd2;
        exp_q.push_back(exp_period(2));
        @(negedge clk);
        reg_wr = 1'b0;
        chk(irq == 1'b0, "R3", int'(irq), 0);
        run_periods(1);
        // R7: other offsets have no effect
        wait_irq();
        wr(12'h22C, 32'd41, 1'b0);
        wr(12'h000, 32'd100, 1'b0);
        rd(12'h234, "R7");
        @(negedge clk);
        chk(irq == 1'b1, "R7", int'(irq), 1);
        rd(12'h22C, "R7");
        @(negedge clk);
        chk(irq == 1'b1, "R7", int'(irq), 1);
        rd(12'h230, "R5");
        run_periods(2);
        // R4: level holds across several expiries without acknowledge
        wr(12'h228, 32'd0, 1'b1);
        wait_irq();
        repeat (3 * DIV) @(negedge clk);
        chk(irq == 1'b1, "R4", int'(irq), 1);
        // R8: acknowledge at the same edge as an expiry
        @(negedge clk);
        while ((tb_cyc % DIV) != 0) @(negedge clk);
        reg_rd = 1'b1; reg_addr = 12'h230;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(irq == 1'b1, "R8", int'(irq), 1);
        rd(12'h230, "R5");
        @(negedge clk);
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule